// File: doc/BRIEF.md
# Dual-Bank Channel Code Register Target on a Two-Wire Serial Bus

This block is a serial-bus target that stores fourteen 8-bit channel codes in each of two banks, named A and B. A system clock much faster than the bus oversamples the SCL and SDA lines. The block finds START and STOP conditions and compares the incoming 7-bit address with a fixed upper part plus one strap pin. It takes write bursts and returns read bursts. Both banks are shown in parallel on output buses, so that converters further along can use them directly.

A write burst always begins with a settings byte. This byte chooses which bank takes channel writes, which bank feeds read bursts, and the oscillator source and lag options. The bytes after it fill channels 1 to 14 in order. A read burst has no pointer phase: it streams channels 1 to 14 of the selected read bank and stops driving the bus when the controller answers with a not-acknowledge. The settings stay in force across transactions until another write replaces them.

Top module: `dac_bank_i2c_target`

## Requirements
- R1: The target answers only to the 7-bit address 1110_10 followed by the `addr_lsb` strap value (0x74 or 0x75). It acknowledges its address by pulling SDA low during the ninth clock. For any other address it gives no acknowledge, drives nothing and changes no state until the next START.
- R2: The eighth bit after START sets the direction. A 0 makes the transfer a write to the target, and a 1 makes it a read from the target.
- R3: The first byte of every write is the settings byte, sent MSB first. Bit 1 selects the write bank (0 = A, 1 = B). Bit 2 selects the read bank. Bit 3 selects the oscillator (1 = external, shown on `osc_ext`). Bit 0 selects lag mode (`lag_mode`). Bits 7 to 4 have no effect.
- R4: On a write, the bytes after the settings byte load channels 1, 2, and onward up to 14 of the write bank, in that order. Every byte is acknowledged, and the other bank does not change. Channel n sits at bits [8n-1:8n-8] of its bank bus.
- R5: Bytes written after channel 14 are acknowledged and thrown away. No channel changes.
- R6: On a read, the target sends channel 1 first, then channel 2 and onward, from the read bank, MSB first. Any byte requested after channel 14 reads as 0xFF, with SDA released.
- R7: After reset, every channel of both banks is 0. `wr_bank_sel`, `rd_bank_sel`, `osc_ext` and `lag_mode` are all 0, and SDA is released.
- R8: The settings persist across STOP and across read transactions. A write that ends early changes only the channels it reached.
- R9: START (SDA falling while SCL is high) resets the channel index and starts address matching again, including as a repeated START. STOP (SDA rising while SCL is high) releases the bus.
- R10: SDA is driven only as a low (`sda_oe` = 1 pulls it low). A not-acknowledge from the controller after a read byte ends the burst and leaves SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_lsb | input | 1 | Strap that sets the address LSB |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| bank_a_flat | output | 112 | Bank A channel codes, channel 1 in the low byte |
| bank_b_flat | output | 112 | Bank B channel codes, channel 1 in the low byte |
| wr_bank_sel | output | 1 | Current write bank (1 = B) |
| rd_bank_sel | output | 1 | Current read bank (1 = B) |
| osc_ext | output | 1 | Oscillator source (1 = external) |
| lag_mode | output | 1 | Lag mode select |

## Verification
A wrong channel index or bank select shows up on the bank buses within a few system cycles after the acknowledge clock of the affected byte. The bench compares every channel of both banks with a model after each transaction. A wrong state machine shows up as a missing or extra acknowledge bit, or as wrong read data, in the very next bus bit. Settings decode errors appear on the four status outputs right after the settings byte is acknowledged.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WR, ST_WACK, ST_RD, ST_RACK
  } bus_state_t;

  typedef struct packed {
    logic osc_ext;
    logic rd_b;
    logic wr_b;
    logic lag;
  } ctrl_t;

  function automatic logic addr_match(input logic [6:0] a, input logic [5:0] hi,
                                      input logic lsb);
    return (a[6:1] == hi) && (a[0] == lsb);
  endfunction

  function automatic ctrl_t decode_ctrl(input logic [7:0] b);
    ctrl_t c;
    c.lag     = b[0];
    c.wr_b    = b[1];
    c.rd_b    = b[2];
    c.osc_ext = b[3];
    return c;
  endfunction

  function automatic logic [4:0] sat_inc(input logic [4:0] idx, input int unsigned lim);
    return (idx >= 5'(lim)) ? 5'(lim) : idx + 5'd1;
  endfunction

endpackage

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_p  <= scl_ff[1];
      sda_p  <= sda_ff[1];
    end
  end

  assign sda_s     = sda_ff[1];
  assign scl_rise  = scl_ff[1] & ~scl_p;
  assign scl_fall  = ~scl_ff[1] & scl_p;
  assign start_det = scl_ff[1] & scl_p & sda_p & ~sda_ff[1];
  assign stop_det  = scl_ff[1] & scl_p & ~sda_p & sda_ff[1];
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import dac_bank_pkg::*;
#(
  parameter int unsigned N_CH    = 14,
  parameter logic [5:0]  ADDR_HI = 6'b111010,
  localparam int unsigned IW     = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_lsb,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    rd_byte,
  output logic [IW-1:0] chan_idx,
  output logic [IW-1:0] wr_idx,
  output logic [7:0]    wr_data,
  output logic          ctrl_we,
  output logic          ch_we,
  output logic          sda_oe,
  output logic          idle
);
  bus_state_t state;
  logic [3:0] bit_cnt;
  logic [7:0] sr;
  logic       is_read, first_byte, mack;

  assign wr_data = sr;
  assign idle    = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      bit_cnt    <= '0;
      sr         <= '0;
      is_read    <= 1'b0;
      first_byte <= 1'b0;
      mack       <= 1'b0;
      chan_idx   <= '0;
      wr_idx     <= '0;
      ctrl_we    <= 1'b0;
      ch_we      <= 1'b0;
      sda_oe     <= 1'b0;
    end else begin
      ctrl_we <= 1'b0;
      ch_we   <= 1'b0;
      if (start_det) begin
        state      <= ST_ADDR;
        bit_cnt    <= '0;
        chan_idx   <= '0;
        first_byte <= 1'b1;
        sda_oe     <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_ADDR: begin
            if (scl_rise) begin
              sr      <= {sr[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              bit_cnt <= '0;
              if (addr_match(sr[7:1], ADDR_HI, addr_lsb)) begin
                is_read <= sr[0];
                sda_oe  <= 1'b1;
                state   <= ST_AACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (is_read) begin
                sr     <= rd_byte;
                sda_oe <= ~rd_byte[7];
                state  <= ST_RD;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (scl_rise) begin
              sr      <= {sr[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              bit_cnt <= '0;
              sda_oe  <= 1'b1;
              state   <= ST_WACK;
              if (first_byte) begin
                ctrl_we    <= 1'b1;
                first_byte <= 1'b0;
              end else if (chan_idx < IW'(N_CH)) begin
                ch_we    <= 1'b1;
                wr_idx   <= chan_idx;
                chan_idx <= sat_inc(chan_idx, N_CH);
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
              state   <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall) begin
              if (bit_cnt == 4'd8) begin
                sda_oe   <= 1'b0;
                bit_cnt  <= '0;
                chan_idx <= sat_inc(chan_idx, N_CH);
                state    <= ST_RACK;
              end else begin
                sr     <= {sr[6:0], 1'b0};
                sda_oe <= ~sr[6];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                sr     <= rd_byte;
                sda_oe <= ~rd_byte[7];
                state  <= ST_RD;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/dac_bank_regs.sv
module dac_bank_regs
  import dac_bank_pkg::*;
#(
  parameter int unsigned N_CH = 14,
  localparam int unsigned IW  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              ch_we,
  input  logic [IW-1:0]     wr_idx,
  input  logic [7:0]        wr_data,
  input  logic [IW-1:0]     rd_idx,
  output logic [7:0]        rd_byte,
  output logic [N_CH*8-1:0] bank_a_flat,
  output logic [N_CH*8-1:0] bank_b_flat,
  output ctrl_t             ctrl
);
  logic [7:0] bank_a [N_CH];
  logic [7:0] bank_b [N_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl <= '0;
    else if (ctrl_we) ctrl <= decode_ctrl(wr_data);
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_a[g] <= '0;
        bank_b[g] <= '0;
      end else if (ch_we && wr_idx == IW'(g)) begin
        if (ctrl.wr_b) bank_b[g] <= wr_data;
        else           bank_a[g] <= wr_data;
      end
    end
    assign bank_a_flat[g*8 +: 8] = bank_a[g];
    assign bank_b_flat[g*8 +: 8] = bank_b[g];
  end

  always_comb begin
    rd_byte = 8'hFF;
    for (int i = 0; i < N_CH; i++)
      if (rd_idx == IW'(i)) rd_byte = ctrl.rd_b ? bank_b[i] : bank_a[i];
  end
endmodule

// File: rtl/dac_bank_i2c_target.sv
module dac_bank_i2c_target
  import dac_bank_pkg::*;
#(
  parameter int unsigned N_CH    = 14,
  parameter logic [5:0]  ADDR_HI = 6'b111010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_lsb,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [N_CH*8-1:0] bank_a_flat,
  output logic [N_CH*8-1:0] bank_b_flat,
  output logic              wr_bank_sel,
  output logic              rd_bank_sel,
  output logic              osc_ext,
  output logic              lag_mode
);
  localparam int unsigned IW = 5;

  logic          sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic          ctrl_we, ch_we, fsm_idle;
  logic [IW-1:0] chan_idx, wr_idx;
  logic [7:0]    wr_data, rd_byte;
  ctrl_t         ctrl;

  i2c_pin_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  i2c_target_fsm #(.N_CH(N_CH), .ADDR_HI(ADDR_HI)) u_fsm (
    .clk(clk), .rst_n(rst_n), .addr_lsb(addr_lsb), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_byte(rd_byte), .chan_idx(chan_idx), .wr_idx(wr_idx), .wr_data(wr_data),
    .ctrl_we(ctrl_we), .ch_we(ch_we), .sda_oe(sda_oe), .idle(fsm_idle)
  );

  dac_bank_regs #(.N_CH(N_CH)) u_regs (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ch_we(ch_we), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(chan_idx), .rd_byte(rd_byte),
    .bank_a_flat(bank_a_flat), .bank_b_flat(bank_b_flat), .ctrl(ctrl)
  );

  assign wr_bank_sel = ctrl.wr_b;
  assign rd_bank_sel = ctrl.rd_b;
  assign osc_ext     = ctrl.osc_ext;
  assign lag_mode    = ctrl.lag;
endmodule

// File: rtl/dac_bank_checker.sv
module dac_bank_checker #(
  parameter int unsigned N_CH = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_det,
  input logic              stop_det,
  input logic              sda_oe,
  input logic              fsm_idle,
  input logic              ctrl_we,
  input logic              ch_we,
  input logic [4:0]        chan_idx,
  input logic              wr_bank_sel,
  input logic              rd_bank_sel,
  input logic              osc_ext,
  input logic              lag_mode,
  input logic [N_CH*8-1:0] bank_a_flat
);
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    fsm_idle |-> !sda_oe); // R1
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe); // R10
  AST_START_CLEARS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> chan_idx == 5'd0); // R9
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    chan_idx <= 5'(N_CH)); // R5
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> $stable({wr_bank_sel, rd_bank_sel, osc_ext, lag_mode})); // R8
  AST_BANK_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ch_we || wr_bank_sel) |=> $stable(bank_a_flat)); // R4
endmodule

bind dac_bank_i2c_target dac_bank_checker #(.N_CH(N_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
  .sda_oe(sda_oe), .fsm_idle(fsm_idle), .ctrl_we(ctrl_we), .ch_we(ch_we),
  .chan_idx(chan_idx), .wr_bank_sel(wr_bank_sel), .rd_bank_sel(rd_bank_sel),
  .osc_ext(osc_ext), .lag_mode(lag_mode), .bank_a_flat(bank_a_flat)
);

// File: tb/test_dac_bank_i2c_target.sv
module test_dac_bank_i2c_target;
  localparam int NCH = 14;
  localparam int Q   = 8;

  logic clk = 1'b0, rst_n = 1'b0, addr_lsb = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, wr_bank_sel, rd_bank_sel, osc_ext, lag_mode;
  logic [NCH*8-1:0] bank_a_flat, bank_b_flat;
  wire  sda_line = sda_m & ~sda_oe;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_a [NCH];
  logic [7:0] exp_b [NCH];
  logic [7:0] tx [20];
  logic [7:0] rx [20];
  logic       ackv [21];
  logic       e_wr = 0, e_rd = 0, e_osc = 0, e_lag = 0;

  always #5 clk = ~clk;

  dac_bank_i2c_target i_dac_bank_i2c_target (
    .clk(clk), .rst_n(rst_n), .addr_lsb(addr_lsb), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .bank_a_flat(bank_a_flat), .bank_b_flat(bank_b_flat),
    .wr_bank_sel(wr_bank_sel), .rd_bank_sel(rd_bank_sel), .osc_ext(osc_ext),
    .lag_mode(lag_mode)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1; wq(Q); scl_m = 1; wq(Q); sda_m = 0; wq(Q); scl_m = 0; wq(Q);
  endtask
  task automatic bus_stop();
    sda_m = 0; wq(Q); scl_m = 1; wq(Q); sda_m = 1; wq(2*Q);
  endtask
  task automatic put_bit(input logic b);
    sda_m = b; wq(Q); scl_m = 1; wq(2*Q); scl_m = 0; wq(Q);
  endtask
  task automatic get_bit(output logic b);
    sda_m = 1; wq(Q); scl_m = 1; wq(Q); b = sda_line; wq(Q); scl_m = 0; wq(Q);
  endtask
  task automatic put_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b); ack = ~b;
  endtask

  // address phase plus n bytes from tx; ackv[0] is address ack
  task automatic wr_xfer(input logic [6:0] a, input int n, input bit stop);
    logic k;
    bus_start();
    put_byte({a, 1'b0}, k); ackv[0] = k;
    for (int i = 0; i < n; i++) begin put_byte(tx[i], k); ackv[i+1] = k; end
    if (stop) bus_stop();
  endtask

  task automatic rd_xfer(input logic [6:0] a, input int n);
    logic k, b;
    logic [7:0] v;
    bus_start();
    put_byte({a, 1'b1}, k); ackv[0] = k;
    for (int i = 0; i < n; i++) begin
      for (int j = 7; j >= 0; j--) begin get_bit(b); v[j] = b; end
      rx[i] = v;
      put_bit(i == n-1);
    end
    wq(Q);
    chk("R10 released after NACK", sda_oe, 0);
    bus_stop();
  endtask

  task automatic check_banks(input string req);
    for (int c = 0; c < NCH; c++) begin
      chk(req, bank_a_flat[c*8 +: 8], exp_a[c]);
      chk(req, bank_b_flat[c*8 +: 8], exp_b[c]);
    end
  endtask

  task automatic check_ctrl(input string req);
    chk(req, {wr_bank_sel, rd_bank_sel, osc_ext, lag_mode}, {e_wr, e_rd, e_osc, e_lag});
  endtask

  task automatic apply_ctrl(input logic [7:0] c);
    e_lag = c[0]; e_wr = c[1]; e_rd = c[2]; e_osc = c[3];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin exp_a[c] = 0; exp_b[c] = 0; end
    wq(4); rst_n = 1; wq(4);
    // R7 reset state
    check_banks("R7 reset banks");
    check_ctrl("R7 reset settings");
    chk("R7 sda released", sda_oe, 0);

    // R4 full write into bank A, settings 0x00
    tx[0] = 8'h00;
    for (int c = 0; c < NCH; c++) begin tx[c+1] = 8'((c*37 + 5) & 255); exp_a[c] = tx[c+1]; end
    wr_xfer(7'h74, NCH+1, 1);
    chk("R1 address ack", ackv[0], 1);
    for (int i = 1; i <= NCH+1; i++) chk("R4 byte ack", ackv[i], 1);
    apply_ctrl(8'h00);
    check_banks("R4 bank A fill");

    // R3 write bank B with settings 0x02 (R2 write direction)
    tx[0] = 8'h02;
    for (int c = 0; c < NCH; c++) begin tx[c+1] = 8'((c*91 + 200) & 255); exp_b[c] = tx[c+1]; end
    wr_xfer(7'h74, NCH+1, 1);
    apply_ctrl(8'h02);
    check_ctrl("R3 write bank B select");
    check_banks("R4 bank B fill, A unchanged");

    // R1 wrong address (strap 0, address 0x75): no ack, no change
    tx[0] = 8'h0F; tx[1] = 8'h11; tx[2] = 8'h22;
    wr_xfer(7'h75, 3, 1);
    chk("R1 mismatch no ack", ackv[0], 0);
    chk("R1 mismatch data no ack", ackv[1], 0);
    check_ctrl("R1 mismatch settings kept");
    check_banks("R1 mismatch banks kept");

    // R1 strap high selects 0x75; R3 high bits ignored, C3/C0 decode
    addr_lsb = 1;
    tx[0] = 8'hF9; tx[1] = 8'h5A; tx[2] = 8'hA5; tx[3] = 8'h3C;
    exp_a[0] = 8'h5A; exp_a[1] = 8'hA5; exp_a[2] = 8'h3C;
    wr_xfer(7'h75, 4, 1);
    chk("R1 strap high ack", ackv[0], 1);
    apply_ctrl(8'hF9);
    check_ctrl("R3 osc/lag decode, high bits ignored");
    check_banks("R8 partial write touches 3 channels");
    wr_xfer(7'h74, 1, 1);
    chk("R1 old address refused", ackv[0], 0);

    // R3 settings byte 0xF0: all settings zero
    tx[0] = 8'hF0;
    wr_xfer(7'h75, 1, 1);
    apply_ctrl(8'hF0);
    check_ctrl("R3 bits 7-4 no effect");

    // R5 overflow writes into bank B (settings 0x06)
    tx[0] = 8'h06;
    for (int c = 0; c < NCH+3; c++) tx[c+1] = 8'(c + 8'h40);
    for (int c = 0; c < NCH; c++) exp_b[c] = tx[c+1];
    wr_xfer(7'h75, NCH+4, 1);
    for (int i = NCH+2; i <= NCH+4; i++) chk("R5 extra byte ack", ackv[i], 1);
    apply_ctrl(8'h06);
    check_banks("R5 extra bytes discarded");

    // R6/R2 read bank B (read select 1), R8 settings persist
    rd_xfer(7'h75, NCH);
    chk("R2 read address ack", ackv[0], 1);
    for (int c = 0; c < NCH; c++) chk("R6 read bank B", rx[c], exp_b[c]);
    check_ctrl("R8 settings persist over read");

    // R9 repeated START: settings 0x00 then read bank A without STOP
    tx[0] = 8'h00;
    wr_xfer(7'h75, 1, 0);
    apply_ctrl(8'h00);
    rd_xfer(7'h75, NCH+2);
    for (int c = 0; c < NCH; c++) chk("R9 repeated START read bank A", rx[c], exp_a[c]);
    chk("R6 beyond last reads FF", rx[NCH], 8'hFF);
    chk("R6 beyond last reads FF", rx[NCH+1], 8'hFF);

    // R9 short read restarts at channel 1
    rd_xfer(7'h75, 2);
    chk("R9 index reset on START", rx[0], exp_a[0]);
    chk("R9 index reset on START", rx[1], exp_a[1]);
    check_banks("R8 banks after reads");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule